// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Detector

This block watches a pair of I2C lines, SCL and SDA, and recognises the two framing events of the bus. A START is SDA going low while SCL is high. A STOP is SDA going high while SCL is high. An SDA edge becomes a condition only if three time windows are met. SCL must have been high long enough. SDA must have been steady at its old level long enough before the edge. After the edge, both lines must keep their new levels for a hold period. An accepted START sets a bus-busy flag and an accepted STOP clears it. The flag, and a one-cycle strobe naming the condition, change a fixed, mode-dependent delay after the SDA edge. Both lines pass through two-stage synchronisers before any of this logic.

The module clock runs at twice the rate of the controller's internal reference clock. Every window is therefore counted in half reference cycles, which makes fractional delays exact. In standard mode the windows come from a 5-bit timing value N. In high-speed mode they are fixed. When a STOP is accepted while the master-mode input is low, an interrupt request pulse is raised in the same cycle as the STOP strobe. Other parts of the controller use the START and STOP strobes directly.

Top module: `i2c_cond_det`

## Requirements
- R1: An accepted START (SDA falling while SCL high) sets `bus_busy_o` to 1 and an accepted STOP (SDA rising while SCL high) clears it to 0. `bus_busy_o` changes only in a cycle in which `start_o` or `stop_o` is high, and the two strobes are never high together.
- R2: Standard mode (`hs_mode_i`=0) uses an effective even value E derived from `tim_val_i`. In module-clock cycles, the SCL-high window is 2E+2, the SDA setup window is E+2, the hold window is E+2 and the flag delay is E+2.
- R3: An SDA edge is ignored when SCL has been high for fewer cycles than the SCL-high window. No strobe is raised and `bus_busy_o` keeps its value.
- R4: An SDA edge is ignored when SDA was stable at its old level for fewer cycles than the setup window, even when the SCL-high window is met.
- R5: A pending condition is dropped, leaving `bus_busy_o` unchanged and no strobe, if SCL goes low or SDA returns to its old level before the hold window has elapsed.
- R6: The strobe and the `bus_busy_o` update appear at the clock edge that comes flag-delay + 2 edges after the edge that first samples the new SDA level on the pin.
- R7: High-speed mode (`hs_mode_i`=1) ignores `tim_val_i` and uses an SCL-high window of 8, setup and hold windows of 4 and a flag delay of 7 module-clock cycles.
- R8: A `tim_val_i` of 0 is used as E=2, and an odd value v is used as E=v+1. An even nonzero value is used as is.
- R9: `irq_o` pulses in exactly the cycle of an accepted STOP when `master_i` was 0 in the cycle before. It never pulses for a START or when `master_i` was 1.
- R10: `start_o`, `stop_o` and `irq_o` are one-cycle pulses, one per accepted condition.
- R11: Synchronous reset (`rst`=1) clears `bus_busy_o`, the strobes, the pending condition and all window counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, twice the internal reference rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| hs_mode_i | input | 1 | 1 selects the fixed high-speed windows |
| master_i | input | 1 | 1 when the controller acts as bus master |
| tim_val_i | input | 5 | Standard-mode timing value N |
| bus_busy_o | output | 1 | Bus-busy flag |
| start_o | output | 1 | One-cycle strobe on an accepted START |
| stop_o | output | 1 | One-cycle strobe on an accepted STOP |
| irq_o | output | 1 | One-cycle interrupt request on a STOP in slave mode |

## Verification
The STOP strobe, the flag clear and the slave interrupt all come from the commit of a single condition. For this reason they must coincide in one cycle, and the interrupt must follow the master-mode level of the cycle before. The bench runs STOPs in both master modes, under fixed and random timing values. It records the first cycle in which any strobe appears, reads the interrupt level in that same cycle, and compares it with the value predicted from `master_i`. It also provokes an SDA edge that fails only the setup window, so the test shows that the setup and release checks are judged separately.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int TIM_W_DEF = 5;
    localparam int CNT_W_DEF = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1
    } seq_e;

    // Effective even timing value: 0 becomes 2, odd v becomes v+1
    function automatic logic [TIM_W_DEF:0] even_val(input logic [TIM_W_DEF-1:0] v);
        logic [TIM_W_DEF:0] ext;
        ext = {1'b0, v};
        if (ext == '0) begin
            even_val = (TIM_W_DEF+1)'(2);
        end else if (ext[0]) begin
            even_val = ext + (TIM_W_DEF+1)'(1);
        end else begin
            even_val = ext;
        end
    endfunction

endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Idle bus level is high, so reset to ones avoids a false edge
    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stage_q[i] <= '1;
            else     stage_q[i] <= stage_d[i];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_timing.sv
module i2c_cond_timing
    import i2c_cond_pkg::*;
#(
    parameter int TW      = TIM_W_DEF,
    parameter int CW      = CNT_W_DEF,
    parameter int HS_REL  = 8,
    parameter int HS_SU   = 4,
    parameter int HS_HD   = 4,
    parameter int HS_FLAG = 7
) (
    input  logic          hs_mode_i,
    input  logic [TW-1:0] tim_val_i,
    output logic [CW-1:0] rel_o,
    output logic [CW-1:0] setup_o,
    output logic [CW-1:0] hold_o,
    output logic [CW-1:0] flag_o
);
    logic [TW:0]   ev;
    logic [CW-1:0] ev_w;

    always_comb begin
        ev   = even_val(tim_val_i);
        ev_w = CW'(ev);
        if (hs_mode_i) begin
            rel_o   = CW'(HS_REL);
            setup_o = CW'(HS_SU);
            hold_o  = CW'(HS_HD);
            flag_o  = CW'(HS_FLAG);
        end else begin
            // counts in half reference cycles: 2*(E+1), 2*(E/2+1)
            rel_o   = (ev_w << 1) + CW'(2);
            setup_o = ev_w + CW'(2);
            hold_o  = ev_w + CW'(2);
            flag_o  = ev_w + CW'(2);
        end
    end
endmodule

// File: rtl/i2c_cond_track.sv
module i2c_cond_track #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_s,
    input  logic          sda_s,
    output logic          sda_edge_o,
    output logic [CW-1:0] scl_run_o,
    output logic [CW-1:0] sda_run_o
);
    localparam logic [CW-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic          sda_p;
        logic [CW-1:0] scl_run;
        logic [CW-1:0] sda_run;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d       = trk_q;
        trk_d.sda_p = sda_s;
        if (!scl_s)                        trk_d.scl_run = '0;
        else if (trk_q.scl_run != RUN_MAX) trk_d.scl_run = trk_q.scl_run + CW'(1);
        if (sda_s != trk_q.sda_p)          trk_d.sda_run = '0;
        else if (trk_q.sda_run != RUN_MAX) trk_d.sda_run = trk_q.sda_run + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q.sda_p   <= 1'b1;
            trk_q.scl_run <= '0;
            trk_q.sda_run <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign sda_edge_o = (sda_s != trk_q.sda_p);
    assign scl_run_o  = trk_q.scl_run;
    assign sda_run_o  = trk_q.sda_run;
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det
    import i2c_cond_pkg::*;
#(
    parameter int TW     = TIM_W_DEF,
    parameter int CW     = CNT_W_DEF,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          hs_mode_i,
    input  logic          master_i,
    input  logic [TW-1:0] tim_val_i,
    output logic          bus_busy_o,
    output logic          start_o,
    output logic          stop_o,
    output logic          irq_o
);
    localparam int LINES = 2;

    typedef struct packed {
        seq_e          seq;
        logic [CW-1:0] cnt;
        logic          tgt;
        logic          busy;
        logic          start;
        logic          stop;
        logic          irq;
    } det_t;

    logic [LINES-1:0] line_s;
    logic             scl_s, sda_s, sda_edge;
    logic [CW-1:0]    scl_run, sda_run;
    logic [CW-1:0]    w_rel, w_setup, w_hold, w_flag;
    det_t             det_d, det_q;

    i2c_cond_sync #(.W(LINES), .STAGES(STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_cond_timing #(.TW(TW), .CW(CW)) timing_i (
        .hs_mode_i (hs_mode_i),
        .tim_val_i (tim_val_i),
        .rel_o     (w_rel),
        .setup_o   (w_setup),
        .hold_o    (w_hold),
        .flag_o    (w_flag)
    );

    i2c_cond_track #(.CW(CW)) track_i (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .sda_edge_o (sda_edge),
        .scl_run_o  (scl_run),
        .sda_run_o  (sda_run)
    );

    always_comb begin
        det_d       = det_q;
        det_d.start = 1'b0;
        det_d.stop  = 1'b0;
        det_d.irq   = 1'b0;
        unique case (det_q.seq)
            SEQ_IDLE: begin
                // qualify an SDA edge against release and setup windows
                if (sda_edge && scl_s && (scl_run >= w_rel) && (sda_run >= w_setup)) begin
                    det_d.seq = SEQ_HOLD;
                    det_d.cnt = CW'(1);
                    det_d.tgt = sda_s;
                end
            end
            SEQ_HOLD: begin
                if ((det_q.cnt < w_hold) && (!scl_s || (sda_s != det_q.tgt))) begin
                    det_d.seq = SEQ_IDLE;
                end else if (det_q.cnt >= w_flag) begin
                    det_d.seq = SEQ_IDLE;
                    if (det_q.tgt) begin
                        det_d.busy = 1'b0;
                        det_d.stop = 1'b1;
                        det_d.irq  = !master_i;
                    end else begin
                        det_d.busy  = 1'b1;
                        det_d.start = 1'b1;
                    end
                end else begin
                    det_d.cnt = det_q.cnt + CW'(1);
                end
            end
            default: det_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q.seq   <= SEQ_IDLE;
            det_q.cnt   <= '0;
            det_q.tgt   <= 1'b0;
            det_q.busy  <= 1'b0;
            det_q.start <= 1'b0;
            det_q.stop  <= 1'b0;
            det_q.irq   <= 1'b0;
        end else begin
            det_q <= det_d;
        end
    end

    assign bus_busy_o = det_q.busy;
    assign start_o    = det_q.start;
    assign stop_o     = det_q.stop;
    assign irq_o      = det_q.irq;
endmodule

// File: rtl/i2c_cond_det_chk.sv
module i2c_cond_det_chk (
    input logic clk,
    input logic rst,
    input logic master_i,
    input logic bus_busy_o,
    input logic start_o,
    input logic stop_o,
    input logic irq_o
);
    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy_o) |-> start_o);
    // R1
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy_o) |-> stop_o);
    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));
    // R9
    irq_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> stop_o);
    // R9
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> (irq_o == !$past(master_i)));
    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    // R10
    stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> !stop_o);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bus_busy_o && !start_o && !stop_o && !irq_o));
endmodule

bind i2c_cond_det i2c_cond_det_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .master_i   (master_i),
    .bus_busy_o (bus_busy_o),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_cond_det_tb_top.sv
module i2c_cond_det_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       hs  = 1'b0;
    logic       mst = 1'b0;
    logic [4:0] tv  = 5'd4;
    logic       busy, st, sp, irq;

    int n_checks = 0;
    int n_err    = 0;
    int n_start  = 0;
    int n_stop   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_det dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda),
        .hs_mode_i  (hs),
        .master_i   (mst),
        .tim_val_i  (tv),
        .bus_busy_o (busy),
        .start_o    (st),
        .stop_o     (sp),
        .irq_o      (irq)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (st) n_start++;
            if (sp) n_stop++;
        end
    end

    function automatic int eff_even(input int v);
        if (v == 0) return 2;
        if (v % 2 == 1) return v + 1;
        return v;
    endfunction

    // flag delay per R2 / R7
    function automatic int flag_dly(input bit h, input int v);
        return h ? 7 : eff_even(v) + 2;
    endfunction

    // negedges from the drive to the visible update per R6
    function automatic int exp_lat(input bit h, input int v);
        return flag_dly(h, v) + 3;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // SCL low, set SDA, SCL high and let the release window pass
    task automatic prep(input bit lvl);
        scl = 1'b0; wait_n(3);
        sda = lvl;  wait_n(3);
        scl = 1'b1; wait_n(80);
    endtask

    // drive the condition edge and time the response
    task automatic cond(input bit to_stop, input int lat, input string tag);
        int  got    = -1;
        int  pulses = 0;
        bit  kind   = 1'b0;
        bit  irq_at = 1'b0;
        bit  mst_at = mst;
        sda = to_stop;
        for (int k = 1; k <= lat + 6; k++) begin
            @(negedge clk);
            if (st || sp) begin
                pulses++;
                if (got < 0) begin
                    got = k; kind = sp; irq_at = irq;
                end
            end
        end
        check(got == lat, {tag, " R6 latency"}, got, lat);
        check(kind == to_stop, {tag, " R1 strobe kind"}, kind, to_stop);
        check(busy == !to_stop, {tag, " R1 busy"}, busy, !to_stop);
        check(pulses == 1, {tag, " R10 single pulse"}, pulses, 1);
        check(irq_at == (to_stop && !mst_at), {tag, " R9 irq"}, irq_at, to_stop && !mst_at);
    endtask

    initial begin
        int s0, p0;
        bit b0;
        void'($urandom(32'd2024));
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        check(!busy && !st && !sp && !irq, "R11 reset state", busy, 0);
        wait_n(80);

        // R2 standard mode, N=4, slave STOP raises irq (R9)
        hs = 1'b0; tv = 5'd4; mst = 1'b0;
        prep(1); cond(0, exp_lat(0, 4), "R2 start");
        prep(0); cond(1, exp_lat(0, 4), "R2 stop slave");
        // R9 master STOP: no irq
        mst = 1'b1;
        prep(1); cond(0, exp_lat(0, 4), "R9 start master");
        prep(0); cond(1, exp_lat(0, 4), "R9 stop master");

        // R7 high-speed mode ignores tim_val
        hs = 1'b1; tv = 5'd30; mst = 1'b0;
        prep(1); cond(0, exp_lat(1, 30), "R7 start");
        prep(0); cond(1, exp_lat(1, 30), "R7 stop");

        // R8 odd and zero values
        hs = 1'b0; tv = 5'd5;
        prep(1); cond(0, exp_lat(0, 5), "R8 odd");
        tv = 5'd0;
        prep(0); cond(1, exp_lat(0, 0), "R8 zero");

        // R3 release too short: SDA falls 2 cycles after SCL rises
        tv = 5'd4;
        scl = 1'b0; wait_n(3); sda = 1'b1; wait_n(3);
        scl = 1'b1; wait_n(2);
        s0 = n_start; b0 = busy;
        sda = 1'b0; wait_n(30);
        check(n_start == s0, "R3 no start strobe", n_start - s0, 0);
        check(busy == b0, "R3 busy kept", busy, b0);

        // R4 setup short: fall fails release (6<10), rise meets release, setup 4<6
        scl = 1'b0; wait_n(3); sda = 1'b1; wait_n(3);
        scl = 1'b1; wait_n(6);
        sda = 1'b0; wait_n(5);
        s0 = n_start; p0 = n_stop; b0 = busy;
        sda = 1'b1; wait_n(30);
        check(n_stop == p0 && n_start == s0, "R4 no strobe", n_stop - p0, 0);
        check(busy == b0, "R4 busy kept", busy, b0);

        // R5 hold broken by SCL falling
        prep(1);
        s0 = n_start;
        sda = 1'b0; wait_n(1); scl = 1'b0; wait_n(30);
        check(n_start == s0, "R5 scl abort", n_start - s0, 0);
        check(busy == 1'b0, "R5 busy kept", busy, 0);
        // R5 hold broken by SDA returning
        prep(1);
        s0 = n_start; p0 = n_stop;
        sda = 1'b0; wait_n(2); sda = 1'b1; wait_n(30);
        check(n_start == s0 && n_stop == p0, "R5 sda abort", n_start - s0, 0);
        check(busy == 1'b0, "R5 busy kept sda", busy, 0);

        // random mix of modes, values and master level
        for (int it = 0; it < 16; it++) begin
            bit h;
            int v;
            h   = 1'($urandom % 2);
            v   = int'($urandom % 32);
            hs  = h; tv = 5'(v);
            mst = 1'($urandom % 2);
            prep(1); wait_n(int'($urandom % 8));
            cond(0, exp_lat(h, v), "R6 random start");
            mst = 1'($urandom % 2);
            prep(0); wait_n(int'($urandom % 8));
            cond(1, exp_lat(h, v), "R9 random stop");
        end

        // R11 reset while busy
        hs = 1'b0; tv = 5'd2;
        prep(1); cond(0, exp_lat(0, 2), "R11 pre start");
        rst = 1'b1; wait_n(2);
        check(!busy && !st && !sp && !irq, "R11 reset clears busy", busy, 0);
        rst = 1'b0; wait_n(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule